// File: doc/BRIEF.md
# 4PPM Timeslot Recovery and Preamble Lock

This block recovers timeslot timing from a 4 Mbps infrared receive stream that uses four-pulse-position modulation. It runs on a 48 MHz reference clock, where one timeslot lasts six cycles and one chip lasts four timeslots. The receive line passes through a two-flop synchroniser. Every level change on the line re-centres a divide-by-six phase counter, and the line is sampled three cycles into each timeslot.

A two-bit timeslot counter groups the samples into chips. Until lock, the block collects four chips at a time and compares them with the preamble chips 1000, 0000, 1010 and 1000, in that order. When a comparison fails, the counter waits through one timeslot, which moves the chip boundary one slot later, and the hunt starts again. When a comparison succeeds, the block raises lock and begins passing chips downstream. When the downstream frame logic detects a framing error or an abort, it pulses the relock input, which drops lock and restarts the hunt. A loopback select replaces the receive pin with the local transmit serial output. Loopback works even while transmit and receive are both active.

Top module: `ppm4_slot_recovery`

## Requirements
- R1: With no line transition, `sample_o` pulses for one cycle in every six cycles.
- R2: A level change on the selected input is presented before clock edge E. `sample_o` is then high in the cycle after edge E+5, and `sample_bit_o` carries the new level. Samples follow every six cycles after that until the next change.
- R3: With `loopback_i` high, the block uses `tx_loop_i` as its line and ignores `rx_pin_i`. With `loopback_i` low, the roles are reversed.
- R4: Reset leaves `slot_idx_o` at 0 and `lock_o` at 0. At each sample strobe, `slot_idx_o` advances by one modulo 4, unless a slip is pending.
- R5: A chip forms at a sample strobe where `slot_idx_o` is 3. Its value holds the last four samples, with the oldest sample in bit 3.
- R6: While unlocked, every fourth chip ends a comparison against 16'h80A8. The first chip sits in the top nibble. On a mismatch, `slot_idx_o` keeps its value through the next sample strobe.
- R7: A matching comparison sets `lock_o` in the cycle that follows the fourth chip.
- R8: `chip_valid_o` pulses only for chips formed while `lock_o` is high. Chips used during the hunt are not delivered.
- R9: `relock_i` clears `lock_o` on the next cycle and restarts the hunt with four new chips. If it coincides with a matching fourth chip, `lock_o` stays low.
- R10: Once locked, chips that differ from the preamble neither drop `lock_o` nor cause a slip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 48 MHz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_pin_i | input | 1 | Raw receive line, asynchronous |
| tx_loop_i | input | 1 | Transmit serial output, used as the line in loopback |
| loopback_i | input | 1 | Selects tx_loop_i as the line |
| relock_i | input | 1 | Drops lock and restarts the preamble hunt |
| sample_o | output | 1 | Mid-timeslot sample strobe |
| sample_bit_o | output | 1 | Line level at the sample strobe |
| slot_idx_o | output | 2 | Current timeslot index within the chip |
| chip_valid_o | output | 1 | Aligned chip available (locked only) |
| chip_o | output | 4 | Chip value, first timeslot in bit 3 |
| lock_o | output | 1 | Preamble lock flag |

## Verification
Two events can land on the same clock edge: a relock request from the frame logic, and the completion of a preamble comparison that succeeds. The bench runs a behavioural model alongside the design. It watches the model for the cycle just before a fourth hunt chip that will match, and raises `relock_i` in exactly that cycle. The test passes only if `lock_o` stays low on the following cycle and the hunt then locks again on later preamble chips. Every output is also compared with the model on every clock.

// File: rtl/ppm4_pkg.sv
package ppm4_pkg;
  localparam int unsigned REF_DIV   = 6;
  localparam int unsigned SLOTS     = 4;
  localparam int unsigned HUNT_CHIPS = 4;
  localparam logic [15:0] PREAMBLE  = 16'h80A8;
  localparam int unsigned SLOT_W    = $clog2(SLOTS);
  typedef logic [SLOTS-1:0] chip_t;
endpackage

// File: rtl/ppm4_line_sync.sv
module ppm4_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic line_o,
  output logic edge_o
);
  // chain[STAGES-1] is the synchronised line, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain <= '0;
    else         chain <= {chain[STAGES-1:0], d_i};
  end

  assign line_o = chain[STAGES-1];
  assign edge_o = chain[STAGES-1] ^ chain[STAGES];
endmodule

// File: rtl/ppm4_phase_gen.sv
module ppm4_phase_gen #(
  parameter int unsigned DIV = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic tick_o
);
  localparam int unsigned PH_W = $clog2(DIV);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(DIV / 2);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ph_q <= '0;
    else if (edge_i)          ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                      ph_q <= ph_q + 1'b1;
  end

  assign tick_o = (ph_q == PH_MID);

  p_phase_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= PH_LAST);
  p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  p_edge_recentre_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> !tick_o);
endmodule

// File: rtl/ppm4_slot_ctr.sv
module ppm4_slot_ctr #(
  parameter int unsigned SLOTS = 4,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             line_i,
  output logic [SW-1:0]    slot_o,
  output logic             chip_stb_o,
  output logic [SLOTS-1:0] chip_o
);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);

  logic [SW-1:0]    slot_q;
  logic [SLOTS-2:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      hist_q <= '0;
    end else if (tick_i) begin
      hist_q <= {hist_q[SLOTS-3:0], line_i};
      if (!hold_i) slot_q <= slot_q + 1'b1;
    end
  end

  assign slot_o     = slot_q;
  assign chip_o     = {hist_q, line_i};
  assign chip_stb_o = tick_i & ~hold_i & (slot_q == SLOT_LAST);

  p_slot_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !hold_i) |=> slot_o == SW'($past(slot_o) + 1'b1));
  p_slot_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(slot_o));
  p_slot_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && hold_i) |=> $stable(slot_o));
endmodule

// File: rtl/ppm4_preamble_hunt.sv
module ppm4_preamble_hunt #(
  parameter int unsigned CHIP_W = 4,
  parameter int unsigned CHIPS  = 4,
  parameter logic [CHIP_W*CHIPS-1:0] PATTERN = 16'h80A8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              chip_stb_i,
  input  logic [CHIP_W-1:0] chip_i,
  input  logic              relock_i,
  output logic              hold_o,
  output logic              lock_o
);
  localparam int unsigned WIN_W = CHIP_W * (CHIPS - 1);
  localparam int unsigned CNT_W = $clog2(CHIPS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CHIPS - 1);

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hold_q, lock_q, match;

  assign match = ({win_q, chip_i} == PATTERN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (chip_stb_i) win_q <= {win_q[WIN_W-CHIP_W-1:0], chip_i};
      if (relock_i) begin
        lock_q <= 1'b0;
        cnt_q  <= '0;
        hold_q <= 1'b0;
      end else begin
        // slip consumed by the strobe it delays
        if (tick_i && hold_q) hold_q <= 1'b0;
        if (chip_stb_i && !lock_q) begin
          if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            if (match) lock_q <= 1'b1;
            else       hold_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign hold_o = hold_q;
  assign lock_o = lock_q;

  p_relock_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_i |=> !lock_o);
  p_lock_on_chip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(chip_stb_i));
  p_lock_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !relock_i) |=> lock_o);
  p_slip_unlocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> !lock_o);
endmodule

// File: rtl/ppm4_slot_recovery.sv
module ppm4_slot_recovery
  import ppm4_pkg::*;
#(
  parameter int unsigned DIV         = REF_DIV,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_pin_i,
  input  logic              tx_loop_i,
  input  logic              loopback_i,
  input  logic              relock_i,
  output logic              sample_o,
  output logic              sample_bit_o,
  output logic [SLOT_W-1:0] slot_idx_o,
  output logic              chip_valid_o,
  output chip_t             chip_o,
  output logic              lock_o
);
  logic  line_in, line, line_edge, tick, hold, chip_stb, lock;
  chip_t chip;

  assign line_in = loopback_i ? tx_loop_i : rx_pin_i;

  ppm4_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(line_in), .line_o(line), .edge_o(line_edge)
  );

  ppm4_phase_gen #(.DIV(DIV)) u_phase (
    .clk_i, .rst_ni, .edge_i(line_edge), .tick_o(tick)
  );

  ppm4_slot_ctr #(.SLOTS(SLOTS)) u_slot (
    .clk_i, .rst_ni, .tick_i(tick), .hold_i(hold), .line_i(line),
    .slot_o(slot_idx_o), .chip_stb_o(chip_stb), .chip_o(chip)
  );

  ppm4_preamble_hunt #(.CHIP_W(SLOTS), .CHIPS(HUNT_CHIPS), .PATTERN(PREAMBLE)) u_hunt (
    .clk_i, .rst_ni, .tick_i(tick), .chip_stb_i(chip_stb), .chip_i(chip),
    .relock_i, .hold_o(hold), .lock_o(lock)
  );

  assign sample_o     = tick;
  assign sample_bit_o = line;
  assign chip_o       = chip;
  assign chip_valid_o = chip_stb & lock;
  assign lock_o       = lock;

  p_valid_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_valid_o |-> (sample_o && slot_idx_o == SLOT_W'(SLOTS - 1)));
  p_valid_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_valid_o |-> lock_o);
endmodule

// File: tb/ppm4_slot_recovery_test.sv
module ppm4_slot_recovery_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic stim = 1'b0, loop_sel = 1'b0, relock_req = 1'b0, relock_col = 1'b0;
  logic rx_pin, tx_bit, relock;
  assign rx_pin = loop_sel ? 1'b1 : stim;
  assign tx_bit = loop_sel ? stim : 1'b0;
  assign relock = relock_req | relock_col;

  logic       sample, sbit, cvalid, lock;
  logic [1:0] slot;
  logic [3:0] chip;

  ppm4_slot_recovery uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_pin_i(rx_pin), .tx_loop_i(tx_bit),
    .loopback_i(loop_sel), .relock_i(relock), .sample_o(sample),
    .sample_bit_o(sbit), .slot_idx_o(slot), .chip_valid_o(cvalid),
    .chip_o(chip), .lock_o(lock)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: timeslot phase, slot index, hunt window
  int m_s1, m_s2, m_s3, m_ph, m_slot, m_hist, m_hold, m_win, m_cnt, m_lock;
  int hold_seen = 0;
  function automatic int m_chip();
    return ((m_hist << 1) | m_s2) & 15;
  endfunction
  function automatic bit m_tick();
    return m_ph == 3;
  endfunction
  function automatic bit m_stb();
    return m_tick() && m_hold == 0 && m_slot == 3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ph = 0; m_slot = 0;
      m_hist = 0; m_hold = 0; m_win = 0; m_cnt = 0; m_lock = 0;
    end else begin
      int in_bit, chp, n_hold, n_lock, n_cnt;
      bit tk, st;
      in_bit = loop_sel ? int'(tx_bit) : int'(rx_pin);
      tk = m_tick(); st = m_stb(); chp = m_chip();
      n_hold = m_hold; n_lock = m_lock; n_cnt = m_cnt;
      if (relock) begin
        n_lock = 0; n_cnt = 0; n_hold = 0;
      end else begin
        if (tk && m_hold != 0) n_hold = 0;
        if (st && m_lock == 0) begin
          if (m_cnt == 3) begin
            n_cnt = 0;
            if ((((m_win << 4) | chp) & 16'hFFFF) == 16'h80A8) n_lock = 1;
            else begin n_hold = 1; hold_seen++; end
          end else n_cnt = m_cnt + 1;
        end
      end
      if (st) m_win = ((m_win << 4) | chp) & 12'hFFF;
      if (tk) begin
        m_hist = ((m_hist << 1) | m_s2) & 7;
        if (m_hold == 0) m_slot = (m_slot + 1) % 4;
      end
      m_ph = (m_s2 != m_s3) ? 0 : ((m_ph == 5) ? 0 : m_ph + 1);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = in_bit;
      m_hold = n_hold; m_lock = n_lock; m_cnt = n_cnt;
    end
  end

  // every-cycle comparison
  bit run_cmp = 1'b0;
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk(sample == m_tick(), "R1 sample_o", sample, m_tick());
      chk(!m_tick() || sbit == m_s2[0], "R2 sample_bit_o", sbit, m_s2);
      chk(slot == m_slot[1:0], m_hold != 0 ? "R6 slot_idx_o" : "R4 slot_idx_o", slot, m_slot);
      chk(cvalid == (m_stb() && m_lock != 0), "R8 chip_valid_o", cvalid, m_stb() && m_lock != 0);
      if (m_stb()) chk(chip == m_chip()[3:0], "R5 chip_o", chip, m_chip());
      chk(lock == m_lock[0], "R7 lock_o", lock, m_lock);
    end
  end

  // collision: relock in the cycle that completes a matching hunt window
  bit col_arm = 1'b0, col_done = 1'b0;
  always @(negedge clk) begin
    if (relock_col) chk(lock == 1'b0, "R9 relock vs match", lock, 0);
    relock_col = 1'b0;
    if (col_arm && !col_done && m_lock == 0 && m_stb() && m_cnt == 3 &&
        ((((m_win << 4) | m_chip()) & 16'hFFFF) == 16'h80A8)) begin
      relock_col = 1'b1;
      col_done = 1'b1;
    end
  end

  bit q[$];
  task automatic push_chip(input logic [3:0] c);
    for (int i = 3; i >= 0; i--) q.push_back(c[i]);
  endtask
  task automatic push_pre(input int n);
    for (int i = 0; i < n; i++) begin
      push_chip(4'b1000); push_chip(4'b0000); push_chip(4'b1010); push_chip(4'b1000);
    end
  endtask
  task automatic play();
    while (q.size() > 0) begin
      stim = q.pop_front();
      repeat (6) @(negedge clk);
    end
  endtask
  task automatic pulse_relock();
    relock_req = 1'b1;
    @(negedge clk);
    relock_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R4 and R7
    chk(slot == 2'd0, "R4 reset slot", slot, 0);
    chk(lock == 1'b0, "R7 reset lock", lock, 0);
    chk(cvalid == 1'b0, "R8 reset valid", cvalid, 0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    repeat (2) @(negedge clk);  // phase offset before first transition

    // direct receive: idle, preamble hunt, data chips while locked
    repeat (8) push_chip(4'b0000);
    push_pre(24);
    play();
    chk(lock == 1'b1, "R7 locked on preamble", lock, 1);
    chk(hold_seen > 0, "R6 slip occurred during hunt", hold_seen, 1);
    push_chip(4'b0100); push_chip(4'b0001); push_chip(4'b0010); push_chip(4'b1000);
    push_chip(4'b0001); push_chip(4'b0100); push_chip(4'b0100); push_chip(4'b0010);
    play();
    chk(lock == 1'b1, "R10 lock held through data", lock, 1);

    // relock then reacquire
    pulse_relock();
    chk(lock == 1'b0, "R9 relock clears lock", lock, 0);
    push_pre(24);
    play();
    chk(lock == 1'b1, "R9 reacquired after relock", lock, 1);

    // relock coinciding with a matching fourth chip
    pulse_relock();
    col_arm = 1'b1;
    push_pre(24);
    play();
    chk(col_done == 1'b1, "R9 collision provoked", col_done, 1);
    chk(lock == 1'b1, "R9 reacquired after collision", lock, 1);

    // loopback: receive pin held high, stream on transmit path
    loop_sel = 1'b1;
    repeat (3) @(negedge clk);
    pulse_relock();
    repeat (4) push_chip(4'b0000);
    push_pre(24);
    push_chip(4'b0010); push_chip(4'b1000);
    play();
    chk(lock == 1'b1, "R3 lock via loopback path", lock, 1);

    repeat (12) @(negedge clk);
    finish_run();
  end
endmodule